// File: doc/BRIEF.md
# ULPI Link Startup Bus Guard

This block sits at the link side of a ULPI connection. It decides when the link may drive the shared 8-bit data bus and what level it puts on the stop line. From reset until the rest of the link says it is ready, the stop line stays high and the bus carries only idle zeros. A transceiver therefore cannot read a left-over byte as a transmit command. Each time the transceiver hands the bus back after sending receive commands, the guard leaves one cycle with no driver. It then drives idle in the first cycle it owns the bus, and only after that passes transmit bytes through.

The stop line also handles low power. While the link keeps the transceiver suspended, the line stays low. An asynchronous wake request raises it at once, with no clock needed, and keeps it high until the restarted clock shows the direction line low. A link hardware reset forces the line high immediately, so a suspended transceiver also wakes after a warm reset.

Transmit bytes come in on a valid/ready stream. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the producer holds `tx_data` unchanged. `tx_ready` depends on the transceiver's NXT throttle, so the transceiver sets the back-pressure.

Top module: `ulpi_link_guard`

## Requirements
- R1: While `rst_n` is low, `ulpi_stp` is 1, `ulpi_data_oe` is 0 and `tx_ready` is 0.
- R2: After reset, `ulpi_stp` stays 1 until the first rising clock edge at which `link_ready` is 1 and `dir` is 0 are both sampled. It falls on that edge. It is never 0 before `link_ready` has been sampled high.
- R3: Once released, the startup hold does not come back until the next reset. `link_ready` falling later has no effect on `ulpi_stp`.
- R4: `ulpi_data_oe` is 0 whenever `dir` is 1. After `dir` falls, `ulpi_data_oe` rises only after a clock edge that samples `dir` low, which leaves one turnaround cycle with no driver.
- R5: In the first cycle of `ulpi_data_oe` after the bus comes back to the link, `ulpi_data_o` is 8'h00 whatever the transmit stream presents.
- R6: In later driven cycles, `ulpi_data_o` equals `tx_data` when `tx_valid` is 1, the startup hold is released and `lp_mode` is 0. Otherwise it is 8'h00.
- R7: `tx_ready` is 1 only when the link has driven the bus since the previous cycle, the startup hold is released, `lp_mode` is 0 and `nxt` is 1. Every byte offered is eventually taken exactly once.
- R8: With `lp_mode` at 1, no startup hold and no pending wake, `ulpi_stp` is 0, including while the clock is stopped.
- R9: A rising `wake_req` drives `ulpi_stp` to 1 at once without a clock edge. The line stays 1 until a clock edge samples `dir` low while `wake_req` is low.
- R10: Pulling `rst_n` low while the clock is stopped drives `ulpi_stp` to 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock from the transceiver; may stop in low power |
| rst_n | input | 1 | Asynchronous active-low link hardware reset |
| dir | input | 1 | Bus direction from transceiver, 1 = transceiver drives |
| nxt | input | 1 | Transceiver throttle, 1 = current byte taken |
| link_ready | input | 1 | Rest of the link has finished startup |
| lp_mode | input | 1 | Link holds the transceiver in low power |
| wake_req | input | 1 | Asynchronous wake request, active high |
| tx_valid | input | 1 | Transmit stream byte valid |
| tx_data | input | 8 | Transmit stream byte |
| tx_ready | output | 1 | Transmit stream byte accepted this cycle |
| ulpi_data_o | output | 8 | Data bus value driven by the link |
| ulpi_data_oe | output | 1 | Data bus output enable |
| ulpi_stp | output | 1 | Stop line to the transceiver |

## Verification
The functions most likely to collide are idle forcing in the turnaround cycle and a transmit byte already waiting on the stream. To provoke this, the bench holds a non-zero byte valid with NXT high across many DIR falls of different lengths. It judges the result by requiring 8'h00 in the first driven cycle and the byte only in the next cycle. A second collision is a wake request still high on the edge where DIR is sampled low, and the stop line must stay high in that case. The bench checks both cases with a behavioural reference model compared on every clock.

// File: rtl/ulpi_guard_pkg.sv
package ulpi_guard_pkg;
  // Ownership phase of the shared data bus as seen by the link.
  typedef enum logic [1:0] {
    BUS_PHY  = 2'd0,  // transceiver owns or just released the bus
    BUS_TURN = 2'd1,  // first cycle link drives: idle only
    BUS_LINK = 2'd2   // link drives stream data
  } bus_phase_e;
endpackage

// File: rtl/ulpi_stp_ctrl.sv
module ulpi_stp_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  input  logic link_ready,
  input  logic wake_req,
  output logic hold_o,
  output logic stp_o
);
  logic hold_q;
  logic wake_q;

  // Startup hold: set by reset, cleared once link ready and bus returned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hold_q <= 1'b1;
    else if (link_ready && !dir) hold_q <= 1'b0;
  end

  // Wake flag: asynchronous set so it works with the clock stopped.
  always_ff @(posedge clk or negedge rst_n or posedge wake_req) begin
    if (!rst_n)        wake_q <= 1'b0;
    else if (wake_req) wake_q <= 1'b1;
    else if (!dir)     wake_q <= 1'b0;
  end

  assign hold_o = hold_q;
  assign stp_o  = hold_q | wake_q;

  // R2: hold drops only after link_ready and dir low were sampled
  a_r2_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> ($past(link_ready) && !$past(dir)));

  // R3: once released the hold stays released until reset
  a_r3_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |=> !hold_q);

  // R9: a pending wake keeps stp high while dir stays high
  a_r9_wake_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && dir) |=> stp_o);
endmodule

// File: rtl/ulpi_bus_turn.sv
module ulpi_bus_turn
  import ulpi_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  output logic oe_o,
  output logic turn_o
);
  bus_phase_e phase_q;
  bus_phase_e phase_d;

  always_comb begin
    if (dir)                    phase_d = BUS_PHY;
    else if (phase_q == BUS_PHY) phase_d = BUS_TURN;
    else                         phase_d = BUS_LINK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= BUS_PHY;
    else        phase_q <= phase_d;
  end

  // Enable drops at once when the transceiver takes the bus.
  assign oe_o   = (phase_q != BUS_PHY) && !dir;
  assign turn_o = (phase_q == BUS_TURN);

  // R4: the enable only rises after an edge that sampled dir low
  a_r4_oe_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> !$past(dir));
endmodule

// File: rtl/ulpi_tx_gate.sv
module ulpi_tx_gate #(
  parameter int DATA_W = 8
) (
  input  logic              oe,
  input  logic              turn,
  input  logic              hold,
  input  logic              lp_mode,
  input  logic              nxt,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] data_o,
  output logic              tx_ready
);
  localparam logic [DATA_W-1:0] IDLE = '0;

  logic pass;

  // Stream data may reach the bus only past turnaround and startup.
  assign pass     = oe && !turn && !hold && !lp_mode;
  assign data_o   = (pass && tx_valid) ? tx_data : IDLE;
  assign tx_ready = pass && nxt;
endmodule

// File: rtl/ulpi_link_guard.sv
module ulpi_link_guard #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir,
  input  logic              nxt,
  input  logic              link_ready,
  input  logic              lp_mode,
  input  logic              wake_req,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic [DATA_W-1:0] ulpi_data_o,
  output logic              ulpi_data_oe,
  output logic              ulpi_stp
);
  logic hold;
  logic turn;

  ulpi_stp_ctrl stp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir        (dir),
    .link_ready (link_ready),
    .wake_req   (wake_req),
    .hold_o     (hold),
    .stp_o      (ulpi_stp)
  );

  ulpi_bus_turn turn_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir    (dir),
    .oe_o   (ulpi_data_oe),
    .turn_o (turn)
  );

  ulpi_tx_gate #(.DATA_W(DATA_W)) gate_i (
    .oe       (ulpi_data_oe),
    .turn     (turn),
    .hold     (hold),
    .lp_mode  (lp_mode),
    .nxt      (nxt),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .data_o   (ulpi_data_o),
    .tx_ready (tx_ready)
  );

  // R5: first driven cycle after regaining the bus carries idle
  a_r5_turn_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_data_oe && !$past(ulpi_data_oe)) |-> (ulpi_data_o == '0));

  // R7: a byte is accepted only once the link already drove the bus
  a_r7_ready_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> $past(ulpi_data_oe));
endmodule

// File: tb/ulpi_link_guard_tb_top.sv
`timescale 1ns/1ps
module ulpi_link_guard_tb_top;
  logic clk_raw = 1'b0;
  logic clk_run = 1'b1;
  logic clk;
  assign clk = clk_raw & clk_run;
  always #2.5 clk_raw = ~clk_raw;

  logic       rst_n = 1'b1;
  logic       dir = 1'b1, nxt = 1'b0, link_ready = 1'b0, lp_mode = 1'b0, wake_req = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, ulpi_data_oe, ulpi_stp;
  logic [7:0] ulpi_data_o;

  ulpi_link_guard dut_i (
    .clk(clk), .rst_n(rst_n), .dir(dir), .nxt(nxt), .link_ready(link_ready),
    .lp_mode(lp_mode), .wake_req(wake_req), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .ulpi_data_o(ulpi_data_o), .ulpi_data_oe(ulpi_data_oe),
    .ulpi_stp(ulpi_stp)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_hold = 1'b1;
  bit m_wake = 1'b0;
  int m_phase = 0;        // 0 transceiver side, 1 first link cycle, 2 link data
  bit seen_ready = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold <= 1'b1; m_phase <= 0; seen_ready <= 1'b0;
    end else begin
      if (link_ready) seen_ready <= 1'b1;
      if (link_ready && !dir) m_hold <= 1'b0;
      if (dir) m_phase <= 0;
      else if (m_phase == 0) m_phase <= 1;
      else m_phase <= 2;
    end
  end

  always @(posedge clk or negedge rst_n or posedge wake_req) begin
    if (!rst_n) m_wake <= 1'b0;
    else if (wake_req) m_wake <= 1'b1;
    else if (!dir) m_wake <= 1'b0;
  end

  // Compare on every running clock, mid-cycle.
  always @(negedge clk) begin
    bit exp_oe;
    bit exp_rdy;
    logic [7:0] exp_d;
    exp_oe  = (m_phase != 0) && !dir;
    exp_rdy = exp_oe && (m_phase == 2) && !m_hold && !lp_mode && nxt;
    chk(ulpi_stp == (m_hold | m_wake), "R2", "stp", ulpi_stp, m_hold | m_wake);
    if (!seen_ready) chk(ulpi_stp == 1'b1, "R2", "stp before ready", ulpi_stp, 1);
    chk(ulpi_data_oe == exp_oe, "R4", "data_oe", ulpi_data_oe, exp_oe);
    if (exp_oe) begin
      if (m_phase == 1) begin
        chk(ulpi_data_o == 8'h00, "R5", "turnaround data", ulpi_data_o, 0);
      end else begin
        exp_d = (m_hold || lp_mode || !tx_valid) ? 8'h00 : tx_data;
        chk(ulpi_data_o == exp_d, "R6", "bus data", ulpi_data_o, exp_d);
      end
    end
    chk(tx_ready == exp_rdy, "R7", "tx_ready", tx_ready, exp_rdy);
  end

  // ---------------- transmit stream producer ----------------
  byte unsigned q[$];
  bit tx_en = 1'b0;
  bit acc = 1'b0;
  int pushed = 0;
  int sent = 0;

  always @(negedge clk) acc = tx_valid && tx_ready;

  always @(posedge clk) begin
    if (acc && q.size() > 0) begin
      void'(q.pop_front());
      sent++;
    end
    acc = 1'b0;
    #1;
    tx_valid = tx_en && (q.size() > 0);
    tx_data  = (q.size() > 0) ? q[0] : 8'h00;
  end

  task automatic push(input byte unsigned b);
    q.push_back(b);
    pushed++;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic stop_clk();
    @(negedge clk_raw);
    clk_run = 1'b0;
  endtask

  task automatic start_clk();
    @(negedge clk_raw);
    clk_run = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #500000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    #1 rst_n = 1'b0;
    step(4);
    chk(ulpi_stp == 1'b1, "R1", "stp in reset", ulpi_stp, 1);
    chk(ulpi_data_oe == 1'b0, "R1", "oe in reset", ulpi_data_oe, 0);
    chk(tx_ready == 1'b0, "R1", "ready in reset", tx_ready, 0);
    rst_n = 1'b1;
    step(3);

    // Bus returned while the link is not ready: idle only, stp held (R2, R6).
    for (int b = 0; b < 6; b++) push(8'hA5 + b[7:0]);
    tx_en = 1'b1; nxt = 1'b1;
    dir = 1'b0;
    step(5);
    dir = 1'b1; link_ready = 1'b1;
    step(2);
    chk(ulpi_stp == 1'b1, "R2", "stp while dir high", ulpi_stp, 1);
    dir = 1'b0;
    step(1);
    chk(ulpi_stp == 1'b0, "R2", "stp released", ulpi_stp, 0);
    for (int i = 0; i < 12; i++) begin
      nxt = (i % 3) != 0;
      step(1);
    end

    // Readiness dropped later: no effect (R3).
    link_ready = 1'b0;
    step(3);
    chk(ulpi_stp == 1'b0, "R3", "stp after ready drop", ulpi_stp, 0);

    // Receive-command bursts of several lengths with bytes waiting (R4, R5).
    for (int k = 0; k < 4; k++) begin
      push(8'h11 * (k + 1));
      push(8'hF0 - k[7:0]);
      nxt = 1'b1;
      dir = 1'b1;
      step(k + 1);
      dir = 1'b0;
      step(3);
    end
    nxt = 1'b1;
    step(6);

    // Low power: stp low, clock stops, async wake (R8, R9).
    tx_en = 1'b0; nxt = 1'b0;
    dir = 1'b1; lp_mode = 1'b1;
    step(3);
    chk(ulpi_stp == 1'b0, "R8", "stp in low power", ulpi_stp, 0);
    stop_clk();
    #7;
    chk(ulpi_stp == 1'b0, "R8", "stp clock stopped", ulpi_stp, 0);
    wake_req = 1'b1;
    #1;
    chk(ulpi_stp == 1'b1, "R9", "stp on wake", ulpi_stp, 1);
    #3 wake_req = 1'b0;
    #5;
    chk(ulpi_stp == 1'b1, "R9", "stp after wake pulse", ulpi_stp, 1);
    start_clk();
    step(3);
    chk(ulpi_stp == 1'b1, "R9", "stp dir still high", ulpi_stp, 1);
    lp_mode = 1'b0;
    wake_req = 1'b1;
    dir = 1'b0;
    step(2);
    chk(ulpi_stp == 1'b1, "R9", "stp wake_req held", ulpi_stp, 1);
    wake_req = 1'b0;
    step(1);
    chk(ulpi_stp == 1'b0, "R9", "stp after dir low", ulpi_stp, 0);
    step(2);

    // Warm reset during suspend with the clock stopped (R10).
    dir = 1'b1; lp_mode = 1'b1;
    step(2);
    stop_clk();
    #5;
    chk(ulpi_stp == 1'b0, "R8", "stp suspended", ulpi_stp, 0);
    rst_n = 1'b0;
    #1;
    chk(ulpi_stp == 1'b1, "R10", "stp on warm reset", ulpi_stp, 1);
    chk(ulpi_data_oe == 1'b0, "R1", "oe on warm reset", ulpi_data_oe, 0);
    #4;
    start_clk();
    step(3);
    rst_n = 1'b1; lp_mode = 1'b0;
    step(2);
    dir = 1'b0;
    step(4);
    chk(ulpi_stp == 1'b1, "R2", "stp before ready", ulpi_stp, 1);
    link_ready = 1'b1;
    for (int b = 0; b < 5; b++) push(8'h30 + b[7:0]);
    tx_en = 1'b1; nxt = 1'b1;
    step(3);
    for (int i = 0; i < 40 && q.size() > 0; i++) begin
      nxt = (i % 2) == 0;
      step(1);
    end
    nxt = 1'b0;
    step(2);
    chk(sent == pushed, "R7", "bytes accepted", sent, pushed);
    chk(q.size() == 0, "R7", "queue drained", q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule